// File: doc/BRIEF.md
# Serial Port Pin Function Multiplexer

This block sits between four shared package pins and a synchronous serial port core. Bit 0 of every pin vector is the serial transmit data pin. Bits 1, 2 and 3 are serial control pins 0, 1 and 2. Each pin has a function bit and a direction bit. While a pin's function bit is clear, the pin is general-purpose I/O driven from a data register. While it is set, the pin is handed to the serial core.

In serial function the pads take their drive and enable from the core. Incoming pad values are synchronized and then steered to the core's receive clock, receive frame sync, transmit frame sync or flag inputs. The steering depends on whether the port runs synchronously or asynchronously. A power-state input selects run, wait or stop:
- Stop releases every pad driver and turns on a keeper on each pin that was driving, so the pin holds its last level.
- Stop also freezes the input samplers.
- Wait behaves exactly like run.

Top module: `spm_pinmux`

## Requirements
- R1: After reset the function, direction and data registers are zero, so every pin is a general-purpose input: `pad_oe`, `pad_keep` and all five core-side inputs are 0.
- R2: A register write is loaded at the clock edge on which `wr_en` is high. `wr_sel` selects the target: 0 is function, 1 is direction, 2 is data, 3 is no target. The effect shows after that edge. For a pin in GPIO mode, `pad_oe` equals its direction bit and `pad_out` equals its data bit.
- R3: For a pin in serial mode, the pad takes its drive value and enable from the core. The transmit data pin is enabled only while `ser_txd_active` is high. Control pin k uses `ser_ctl_out[k]` and `ser_ctl_oe[k]`.
- R4: A core-side input from a pin is 0 unless that pin is in serial mode and its core output-enable request is low.
- R5: With `sync_mode` low, `rx_clk_in` follows control pin 0 through a two-stage synchronizer and a qualifier. The qualifier changes only after three consecutive samples that differ from its current value, so a pulse of one or two clocks never reaches the core.
- R6: With `sync_mode` high, `flag0_in` and `flag1_in` carry synchronized control pins 0 and 1, and `rx_clk_in` is 0. With `sync_mode` low, both flag inputs are 0.
- R7: `tx_fs_in` comes from control pin 2 in both modes. `rx_fs_in` comes from control pin 1 when `sync_mode` is low and from control pin 2 when it is high.
- R8: With `pm_state` = 2 (stop), all `pad_oe` are 0. `pad_keep` equals the output enables of the last cycle before stop, and `pad_out` holds its last value. Pad inputs are ignored: the synchronizers hold, and register writes do not reach the pads until stop ends.
- R9: `pm_state` = 1 (wait) and `pm_state` = 3 behave exactly like run (0). `pad_keep` is 0 whenever the block is not in stop.
- R10: `rd_data` returns the data register bit for a GPIO output pin. For every other pin it returns the synchronized pad value, which appears two clocks after the pad changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 function, 1 direction, 2 data |
| wr_data | input | 4 | Write value, one bit per pin |
| rd_data | output | 4 | GPIO data readback |
| pm_state | input | 2 | Power state: 0 run, 1 wait, 2 stop |
| sync_mode | input | 1 | 1 = synchronous serial operation |
| pad_in | input | 4 | Pad receive values |
| pad_out | output | 4 | Pad drive values |
| pad_oe | output | 4 | Pad driver enables |
| pad_keep | output | 4 | Pad keeper enables |
| ser_txd | input | 1 | Core transmit data |
| ser_txd_active | input | 1 | Core is shifting out transmit data |
| ser_ctl_out | input | 3 | Core drive values for control pins 0..2 |
| ser_ctl_oe | input | 3 | Core output-enable requests for control pins 0..2 |
| rx_clk_in | output | 1 | Qualified receive clock to the core |
| rx_fs_in | output | 1 | Receive frame sync to the core |
| tx_fs_in | output | 1 | Transmit frame sync to the core |
| flag0_in | output | 1 | Serial flag 0 input to the core |
| flag1_in | output | 1 | Serial flag 1 input to the core |

## Verification
The assertions check on every cycle:
- the one-edge latency of register writes;
- the GPIO drive enable;
- tri-stating, keeper capture and output hold in stop;
- the absence of keeper activity outside stop;
- the gating of core inputs by mode and function.

Only the bench scenarios can show the following:
- the glitch rejection of the receive clock qualifier;
- which pin feeds the receive frame sync in each mode;
- that pad inputs are frozen during stop;
- that wait leaves readback and drive unchanged.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int NUM_PINS = 4;
  localparam int PIN_TXD  = 0;
  localparam int PIN_SC0  = 1;
  localparam int PIN_SC1  = 2;
  localparam int PIN_SC2  = 3;

  typedef enum logic [1:0] {
    SEL_FUNC = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_WAIT = 2'd1,
    PM_STOP = 2'd2,
    PM_RSVD = 2'd3
  } pm_e;

  typedef logic [NUM_PINS-1:0] pinvec_t;

  // drive enable: GPIO direction or serial request, chosen per pin
  function automatic pinvec_t mux_oe(pinvec_t func, pinvec_t dir, pinvec_t ser_oe);
    return (~func & dir) | (func & ser_oe);
  endfunction

  function automatic pinvec_t mux_out(pinvec_t func, pinvec_t data, pinvec_t ser_out);
    return (~func & data) | (func & ser_out);
  endfunction

  // readback: register value for GPIO outputs, sampled pad otherwise
  function automatic pinvec_t gpio_read(pinvec_t func, pinvec_t dir, pinvec_t data,
                                        pinvec_t sampled);
    pinvec_t drv;
    drv = dir & ~func;
    return (drv & data) | (~drv & sampled);
  endfunction
endpackage

// File: rtl/spm_regs.sv
module spm_regs
  import spm_pkg::*;
#(
  parameter int N = NUM_PINS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] func_q,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= '0;
      dir_q  <= '0;
      data_q <= '0;
    end else if (wr_en) begin
      unique case (wr_sel_e'(wr_sel))
        SEL_FUNC: func_q <= wr_data;
        SEL_DIR:  dir_q  <= wr_data;
        SEL_DATA: data_q <= wr_data;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/spm_in_sync.sv
module spm_in_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else if (!hold) begin
      stg[0] <= pad_in;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/spm_qual.sv
module spm_qual #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic din,
  output logic dout
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] CMAX = CW'(LEN - 1);

  logic [CW-1:0] cnt;
  logic          differs;
  logic          flip;

  assign differs = din ^ dout;
  assign flip    = differs && (cnt == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= 1'b0;
      cnt  <= '0;
    end else if (!hold) begin
      if (!differs) begin
        cnt <= '0;
      end else if (flip) begin
        dout <= din;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spm_keeper.sv
module spm_keeper #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop,
  input  logic [N-1:0] live_oe,
  input  logic [N-1:0] live_out,
  output logic [N-1:0] pad_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_keep
);
  logic [N-1:0] last_oe;
  logic [N-1:0] last_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_oe  <= '0;
      last_out <= '0;
    end else if (!stop) begin
      last_oe  <= live_oe;
      last_out <= live_out;
    end
  end

  always_comb begin
    if (stop) begin
      pad_oe   = '0;
      pad_out  = last_out;
      pad_keep = last_oe;
    end else begin
      pad_oe   = live_oe;
      pad_out  = live_out;
      pad_keep = '0;
    end
  end
endmodule

// File: rtl/spm_pinmux.sv
module spm_pinmux
  import spm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [3:0] wr_data,
  output logic [3:0] rd_data,
  input  logic [1:0] pm_state,
  input  logic       sync_mode,
  input  logic [3:0] pad_in,
  output logic [3:0] pad_out,
  output logic [3:0] pad_oe,
  output logic [3:0] pad_keep,
  input  logic       ser_txd,
  input  logic       ser_txd_active,
  input  logic [2:0] ser_ctl_out,
  input  logic [2:0] ser_ctl_oe,
  output logic       rx_clk_in,
  output logic       rx_fs_in,
  output logic       tx_fs_in,
  output logic       flag0_in,
  output logic       flag1_in
);
  localparam int N = NUM_PINS;

  pinvec_t ctrl_q, dir_q, data_q;
  pinvec_t sampled;
  pinvec_t ser_oe_v, ser_out_v;
  pinvec_t live_oe, live_out;
  logic    stop_now;
  logic    sc0_qual;
  logic [N-1:1] in_ok;

  assign stop_now  = (pm_e'(pm_state) == PM_STOP);
  assign ser_oe_v  = {ser_ctl_oe, ser_txd_active};
  assign ser_out_v = {ser_ctl_out, ser_txd};

  spm_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .func_q(ctrl_q), .dir_q(dir_q), .data_q(data_q)
  );

  spm_in_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .hold(stop_now), .pad_in(pad_in), .sync_o(sampled)
  );

  spm_qual #(.LEN(QUAL_LEN)) u_qual (
    .clk(clk), .rst_n(rst_n), .hold(stop_now), .din(sampled[PIN_SC0]), .dout(sc0_qual)
  );

  assign live_oe  = mux_oe(ctrl_q, dir_q, ser_oe_v);
  assign live_out = mux_out(ctrl_q, data_q, ser_out_v);

  spm_keeper #(.N(N)) u_keep (
    .clk(clk), .rst_n(rst_n), .stop(stop_now), .live_oe(live_oe), .live_out(live_out),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_keep(pad_keep)
  );

  // control pins deliver input only in serial mode while the core is not driving
  for (genvar p = 1; p < N; p++) begin : g_inok
    assign in_ok[p] = ctrl_q[p] & ~ser_oe_v[p];
  end

  assign rx_clk_in = ~sync_mode & in_ok[PIN_SC0] & sc0_qual;
  assign flag0_in  =  sync_mode & in_ok[PIN_SC0] & sampled[PIN_SC0];
  assign flag1_in  =  sync_mode & in_ok[PIN_SC1] & sampled[PIN_SC1];
  assign tx_fs_in  =  in_ok[PIN_SC2] & sampled[PIN_SC2];
  assign rx_fs_in  =  sync_mode ? (in_ok[PIN_SC2] & sampled[PIN_SC2])
                                : (in_ok[PIN_SC1] & sampled[PIN_SC1]);

  assign rd_data = gpio_read(ctrl_q, dir_q, data_q, sampled);
endmodule

// File: rtl/spm_pinmux_chk.sv
module spm_pinmux_chk
  import spm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [3:0] wr_data,
  input logic [1:0] pm_state,
  input logic       sync_mode,
  input logic [3:0] ctrl_q,
  input logic [3:0] dir_q,
  input logic [3:0] pad_oe,
  input logic [3:0] pad_out,
  input logic [3:0] pad_keep,
  input logic       rx_clk_in,
  input logic       flag0_in,
  input logic       flag1_in
);
  logic in_stop;
  assign in_stop = (pm_state == PM_STOP);

  AST_FUNC_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_FUNC) |=> (ctrl_q == $past(wr_data))); // R2
  AST_DIR_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_DIR) |=> (dir_q == $past(wr_data))); // R2
  AST_GPIO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stop |-> ((pad_oe & ~ctrl_q) == (dir_q & ~ctrl_q))); // R2
  AST_GPIO_NO_CORE_IN: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[1] |-> (!rx_clk_in && !flag0_in)); // R4
  AST_SYNC_NO_RXCLK: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |-> !rx_clk_in); // R6
  AST_ASYNC_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> (!flag0_in && !flag1_in)); // R6
  AST_STOP_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop |-> (pad_oe == 4'b0000)); // R8
  AST_STOP_KEEP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && $past(pm_state) != PM_STOP) |-> (pad_keep == $past(pad_oe))); // R8
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && $past(pm_state) == PM_STOP) |-> ($stable(pad_out) && $stable(pad_keep))); // R8
  AST_RUN_NO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stop |-> (pad_keep == 4'b0000)); // R9
endmodule

bind spm_pinmux spm_pinmux_chk i_chk (.*);

// File: tb/test_spm_pinmux.sv
module test_spm_pinmux;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [3:0] wr_data = '0;
  logic [3:0] rd_data;
  logic [1:0] pm_state = 2'd0;
  logic       sync_mode = 1'b0;
  logic [3:0] pad_in = '0;
  logic [3:0] pad_out, pad_oe, pad_keep;
  logic       ser_txd = 1'b0;
  logic       ser_txd_active = 1'b0;
  logic [2:0] ser_ctl_out = '0;
  logic [2:0] ser_ctl_oe = '0;
  logic       rx_clk_in, rx_fs_in, tx_fs_in, flag0_in, flag1_in;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  typedef enum int {OB_OE, OB_OUT, OB_KEEP, OB_RD, OB_CORE} obs_e;
  typedef struct {
    string      req;
    obs_e       sel;
    logic [4:0] exp;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spm_pinmux i_spm_pinmux (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_data(rd_data), .pm_state(pm_state), .sync_mode(sync_mode), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_keep(pad_keep), .ser_txd(ser_txd),
    .ser_txd_active(ser_txd_active), .ser_ctl_out(ser_ctl_out), .ser_ctl_oe(ser_ctl_oe),
    .rx_clk_in(rx_clk_in), .rx_fs_in(rx_fs_in), .tx_fs_in(tx_fs_in),
    .flag0_in(flag0_in), .flag1_in(flag1_in)
  );

  function automatic logic [4:0] observe(obs_e s);
    case (s)
      OB_OE:   return {1'b0, pad_oe};
      OB_OUT:  return {1'b0, pad_out};
      OB_KEEP: return {1'b0, pad_keep};
      OB_RD:   return {1'b0, rd_data};
      default: return {flag1_in, flag0_in, tx_fs_in, rx_fs_in, rx_clk_in};
    endcase
  endfunction

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [4:0] act;
      it  = sb_q.pop_front();
      act = observe(it.sel);
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s %s: actual %b expected %b", it.req, it.sel.name(), act, it.exp);
      end
    end
  end

  // driver: queue an expectation and let the monitor consume it
  task automatic expect_obs(string req, obs_e sel, logic [4:0] exp);
    sb_q.push_back('{req, sel, exp});
    @(negedge clk);
    #1;
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic reg_write(logic [1:0] sel, logic [3:0] val);
    @(posedge clk);
    #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(posedge clk);
    #1;
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    expect_obs("R1", OB_OE,   5'b00000);
    expect_obs("R1", OB_KEEP, 5'b00000);
    expect_obs("R1", OB_CORE, 5'b00000);
    expect_obs("R1", OB_RD,   5'b00000);

    // R10 input readback after synchronizer
    pad_in = 4'b0101;
    cycles(4);
    expect_obs("R10", OB_RD, 5'b00101);
    expect_obs("R4",  OB_CORE, 5'b00000);

    // R2 GPIO drive
    reg_write(2'd2, 4'b0110);
    reg_write(2'd1, 4'b0011);
    expect_obs("R2",  OB_OE,  5'b00011);
    expect_obs("R2",  OB_OUT, 5'b00110);
    expect_obs("R10", OB_RD,  5'b00110);
    reg_write(2'd3, 4'b1111);   // no target
    expect_obs("R2",  OB_OE,  5'b00011);

    // R3 serial drive
    ser_txd = 1'b1; ser_txd_active = 1'b1;
    ser_ctl_out = 3'b010; ser_ctl_oe = 3'b010;
    reg_write(2'd0, 4'b1111);
    expect_obs("R3", OB_OE,  5'b00101);
    expect_obs("R3", OB_OUT, 5'b00101);
    ser_txd_active = 1'b0;
    expect_obs("R3", OB_OE,  5'b00100);

    // R5 R7 asynchronous routing
    ser_ctl_oe = 3'b000;
    sync_mode = 1'b0;
    pad_in = 4'b0110;
    cycles(10);
    expect_obs("R5", OB_CORE, 5'b00011);
    sync_mode = 1'b1;
    expect_obs("R6", OB_CORE, 5'b11000);
    pad_in = 4'b1110;
    cycles(4);
    expect_obs("R7", OB_CORE, 5'b11110);
    sync_mode = 1'b0;
    cycles(6);
    expect_obs("R7", OB_CORE, 5'b00111);
    ser_ctl_oe = 3'b011;
    expect_obs("R4", OB_CORE, 5'b00100);
    ser_ctl_oe = 3'b000;

    // R5 glitch rejection
    pad_in = 4'b0000;
    cycles(10);
    expect_obs("R5", OB_CORE, 5'b00000);
    pad_in = 4'b0010;
    cycles(2);
    pad_in = 4'b0000;
    for (int i = 0; i < 8; i++) expect_obs("R5", OB_CORE, 5'b00000);
    pad_in = 4'b0010;
    cycles(8);
    expect_obs("R5", OB_CORE, 5'b00001);

    // R8 stop with GPIO pins
    reg_write(2'd0, 4'b0000);
    reg_write(2'd2, 4'b0110);
    pad_in = 4'b0101;
    cycles(4);
    expect_obs("R8", OB_OE, 5'b00011);
    pm_state = 2'd2;
    expect_obs("R8", OB_OE,   5'b00000);
    expect_obs("R8", OB_KEEP, 5'b00011);
    expect_obs("R8", OB_OUT,  5'b00110);
    pad_in = 4'b1010;
    cycles(5);
    expect_obs("R8", OB_RD, 5'b00110);
    reg_write(2'd2, 4'b1001);
    expect_obs("R8", OB_OUT, 5'b00110);
    pm_state = 2'd0;
    expect_obs("R8", OB_OUT,  5'b01001);
    expect_obs("R8", OB_KEEP, 5'b00000);
    cycles(4);
    expect_obs("R10", OB_RD, 5'b01001);

    // R9 wait behaves as run
    pm_state = 2'd1;
    expect_obs("R9", OB_OE,   5'b00011);
    expect_obs("R9", OB_KEEP, 5'b00000);
    expect_obs("R9", OB_OUT,  5'b01001);
    pad_in = 4'b0101;
    cycles(4);
    expect_obs("R9", OB_RD, 5'b00101);
    pm_state = 2'd3;
    expect_obs("R9", OB_OE, 5'b00011);
    pm_state = 2'd0;

    cycles(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule